// File: doc/BRIEF.md
# Microcontroller Next-PC Unit

This block works out the program counter that follows one instruction of an 8-bit accumulator machine with a 16-bit code space. A fetch stage supplies the current PC, the opcode byte, and up to two operand bytes. The execution context supplies the values a branch may depend on: the accumulator, the 16-bit data pointer, the carry flag, an already-read bit value, the two bytes a compare-and-branch weighs, the pre-decrement loop counter value, and the two stack bytes a return pops. On each cycle with `valid` high, the unit registers the next PC, a taken flag and the resulting carry. These appear on the outputs one clock later.

For opcodes that do not transfer control, the caller supplies the instruction length on `seqLen` and the PC advances by that amount. Control-transfer opcodes carry their own lengths. Every relative branch adds its sign-extended offset byte to the address of the following instruction. All PC arithmetic wraps modulo 65536. Operand fetch, stack pointer movement, pushing return addresses, and clearing a tested bit are left to the surrounding core.

Top module: `npc_unit`

## Requirements
- R1: After reset, `outValid`, `nextPc`, `taken` and `carryOut` are all zero.
- R2: With `valid` high, the outputs change at the next rising edge and `outValid` is 1. With `valid` low, `nextPc`, `taken` and `carryOut` keep their values and `outValid` is 0. For an opcode not named in R3 to R12, `nextPc` = `pc` + `seqLen` (`seqLen` is 1, 2 or 3) and `taken` is 0.
- R3: An opcode whose low nibble is 0x1 is an in-page jump or call. Its target is bits 15:11 of `pc`+2, then opcode bits 7:5, then `op1` (11 low bits in all). `taken` is 1.
- R4: Opcodes 0x02 and 0x12 jump to {`op1`,`op2`}, with `op1` as the high byte. `taken` is 1.
- R5: Opcodes 0x22 and 0x32 return to {`stackHi`,`stackLo`}. `taken` is 1.
- R6: Opcode 0x80 always branches to `pc`+2+sext(`op1`).
- R7: Opcode 0x40 branches when `carryIn` is 1, and 0x50 branches when it is 0. The length is 2, and the offset is `op1`.
- R8: Opcodes 0x20 and 0x10 branch when `bitVal` is 1, and 0x30 branches when it is 0. The length is 3, and the offset is `op2`.
- R9: Opcode 0x60 branches when `acc` is zero, and 0x70 branches when it is non-zero. The length is 2, and the offset is `op1`.
- R10: Opcode 0x73 jumps to `dptr` plus `acc` zero-extended. `taken` is 1.
- R11: Opcodes 0xB4 to 0xBF have length 3 and offset `op2`. They branch when `cmpA` differs from `cmpB`, and set `carryOut` to 1 exactly when `cmpA` < `cmpB` (unsigned). Every other opcode passes `carryIn` to `carryOut`.
- R12: Opcode 0xD5 has length 3 with offset `op2`. Opcodes 0xD8 to 0xDF have length 2 with offset `op1`. Both branch when `loopVal` is not 1.
- R13: A conditional branch that is not taken gives `pc`+length with `taken` 0. All targets wrap modulo 2^16, and negative offsets reach backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Evaluate this cycle's instruction |
| pc | input | 16 | Address of the current instruction |
| opcode | input | 8 | Opcode byte |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| seqLen | input | 2 | Length of a non-branching instruction (1 to 3) |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| carryIn | input | 1 | Current carry flag |
| bitVal | input | 1 | Value of the addressed bit |
| cmpA | input | 8 | First compare operand |
| cmpB | input | 8 | Second compare operand |
| loopVal | input | 8 | Loop counter value before decrement |
| stackHi | input | 8 | Popped high return byte |
| stackLo | input | 8 | Popped low return byte |
| outValid | output | 1 | Outputs hold a fresh result |
| nextPc | output | 16 | Registered next program counter |
| taken | output | 1 | Control was transferred |
| carryOut | output | 1 | Carry after the instruction |

## Verification
The bench sweeps every opcode value against six context patterns. The patterns place the PC at 0x0000, near 0x7FFF, at 0xFFFE and at 2 KiB page edges, and use offsets of 0x7F, 0x80, 0xFF and 0xFE, so that all of these are exercised:
- a sign-extension error shows up as a branch landing 256 bytes off;
- a relative base of `pc` instead of `pc`+length shows up as an error of 2 or 3;
- taking the in-page page bits from `pc` rather than `pc`+2 sends a jump that sits just below a page edge into the wrong page.

A loop counter of 1 and equal compare operands check that those branches fall through and that the compare carry is cleared. Swapping the byte order of the long-jump or return target, or testing a condition with the wrong polarity, fails the sweep on the first such opcode.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int PC_W   = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;
  localparam int PAGE_W = 3;
  localparam int HIGH_W = PC_W - PAGE_W - BYTE_W;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_PAGE,
    TGT_LONG,
    TGT_RET,
    TGT_REL,
    TGT_IND
  } tgt_e;

  typedef struct packed {
    tgt_e             tgtSel;
    logic             relFromOp2;
    logic [LEN_W-1:0] insLen;
    logic             taken;
    logic             cmpOp;
  } npc_strobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [LEN_W-1:0]  seqLen,
  input  logic [BYTE_W-1:0] acc,
  input  logic              carryIn,
  input  logic              bitVal,
  input  logic [BYTE_W-1:0] cmpA,
  input  logic [BYTE_W-1:0] cmpB,
  input  logic [BYTE_W-1:0] loopVal,
  output npc_strobe_t       strobe
);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic isPage, isLong, isRet, isShort, isCy, isBit, isZero, isInd, isCmp, isLoop;
  logic isCond, condTrue;

  assign isPage  = (opcode[3:0] == 4'h1);
  assign isLong  = (opcode == 8'h02) || (opcode == 8'h12);
  assign isRet   = (opcode == 8'h22) || (opcode == 8'h32);
  assign isShort = (opcode == 8'h80);
  assign isCy    = (opcode == 8'h40) || (opcode == 8'h50);
  assign isBit   = (opcode == 8'h10) || (opcode == 8'h20) || (opcode == 8'h30);
  assign isZero  = (opcode == 8'h60) || (opcode == 8'h70);
  assign isInd   = (opcode == 8'h73);
  assign isCmp   = (opcode[7:4] == 4'hB) && (opcode[3:2] != 2'b00);
  assign isLoop  = (opcode == 8'hD5) || (opcode[7:3] == 5'b11011);

  always_comb begin
    strobe        = '0;
    strobe.tgtSel = TGT_SEQ;
    strobe.insLen = seqLen;
    isCond        = 1'b0;
    condTrue      = 1'b0;
    if (isPage) begin
      strobe.tgtSel = TGT_PAGE;
      strobe.insLen = 2'd2;
      strobe.taken  = 1'b1;
    end else if (isLong) begin
      strobe.tgtSel = TGT_LONG;
      strobe.insLen = 2'd3;
      strobe.taken  = 1'b1;
    end else if (isRet) begin
      strobe.tgtSel = TGT_RET;
      strobe.insLen = 2'd1;
      strobe.taken  = 1'b1;
    end else if (isInd) begin
      strobe.tgtSel = TGT_IND;
      strobe.insLen = 2'd1;
      strobe.taken  = 1'b1;
    end else if (isShort) begin
      strobe.insLen = 2'd2;
      isCond        = 1'b1;
      condTrue      = 1'b1;
    end else if (isCy) begin
      strobe.insLen = 2'd2;
      isCond        = 1'b1;
      condTrue      = carryIn ^ opcode[4];
    end else if (isBit) begin
      strobe.insLen     = 2'd3;
      strobe.relFromOp2 = 1'b1;
      isCond            = 1'b1;
      condTrue          = bitVal ^ (opcode == 8'h30);
    end else if (isZero) begin
      strobe.insLen = 2'd2;
      isCond        = 1'b1;
      condTrue      = (acc == '0) ^ opcode[4];
    end else if (isCmp) begin
      strobe.insLen     = 2'd3;
      strobe.relFromOp2 = 1'b1;
      strobe.cmpOp      = 1'b1;
      isCond            = 1'b1;
      condTrue          = (cmpA != cmpB);
    end else if (isLoop) begin
      strobe.insLen     = opcode[3] ? 2'd2 : 2'd3;
      strobe.relFromOp2 = ~opcode[3];
      isCond            = 1'b1;
      condTrue          = (loopVal != ONE);
    end
    if (isCond) begin
      strobe.tgtSel = condTrue ? TGT_REL : TGT_SEQ;
      strobe.taken  = condTrue;
    end
  end

  // R3 R4 R5 R10 R11 R12: opcode classes never overlap
  decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isPage, isLong, isRet, isShort, isCy, isBit, isZero, isInd, isCmp, isLoop}));

  // R2
  seq_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && strobe.tgtSel == TGT_SEQ) |-> (strobe.insLen != 2'd0));
endmodule

// File: rtl/npc_dp.sv
module npc_dp
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  npc_strobe_t       strobe,
  input  logic [PC_W-1:0]   pc,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              carryIn,
  input  logic [BYTE_W-1:0] cmpA,
  input  logic [BYTE_W-1:0] cmpB,
  input  logic [BYTE_W-1:0] stackHi,
  input  logic [BYTE_W-1:0] stackLo,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              carryOut
);
  logic [PC_W-1:0]   seqPc, relPc, pagePc, indPc, tgtPc;
  logic [BYTE_W-1:0] relByte;

  assign seqPc   = pc + {{(PC_W-LEN_W){1'b0}}, strobe.insLen};
  assign relByte = strobe.relFromOp2 ? op2 : op1;
  assign relPc   = seqPc + {{(PC_W-BYTE_W){relByte[BYTE_W-1]}}, relByte};
  assign pagePc  = {seqPc[PC_W-1 -: HIGH_W], opcode[BYTE_W-1 -: PAGE_W], op1};
  assign indPc   = dptr + {{(PC_W-BYTE_W){1'b0}}, acc};

  always_comb begin
    case (strobe.tgtSel)
      TGT_PAGE: tgtPc = pagePc;
      TGT_LONG: tgtPc = {op1, op2};
      TGT_RET:  tgtPc = {stackHi, stackLo};
      TGT_REL:  tgtPc = relPc;
      TGT_IND:  tgtPc = indPc;
      default:  tgtPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      nextPc   <= '0;
      taken    <= 1'b0;
      carryOut <= 1'b0;
    end else begin
      outValid <= valid;
      if (valid) begin
        nextPc   <= tgtPc;
        taken    <= strobe.taken;
        carryOut <= strobe.cmpOp ? (cmpA < cmpB) : carryIn;
      end
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(nextPc) && $stable(taken) && $stable(carryOut) && !outValid));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> outValid);

  // R11
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !strobe.cmpOp) |=> (carryOut == $past(carryIn)));

  // R11
  cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && strobe.cmpOp && cmpA == cmpB) |=> (!carryOut && !taken));

  // R13
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !strobe.taken) |=> (nextPc == $past(seqPc)));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [PC_W-1:0]   pc,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  input  logic [LEN_W-1:0]  seqLen,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              carryIn,
  input  logic              bitVal,
  input  logic [BYTE_W-1:0] cmpA,
  input  logic [BYTE_W-1:0] cmpB,
  input  logic [BYTE_W-1:0] loopVal,
  input  logic [BYTE_W-1:0] stackHi,
  input  logic [BYTE_W-1:0] stackLo,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              carryOut
);
  npc_strobe_t strobe;

  npc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .seqLen(seqLen),
    .acc(acc), .carryIn(carryIn), .bitVal(bitVal), .cmpA(cmpA), .cmpB(cmpB),
    .loopVal(loopVal), .strobe(strobe)
  );

  npc_dp u_dp (
    .clk(clk), .rst_n(rst_n), .valid(valid), .strobe(strobe), .pc(pc),
    .opcode(opcode), .op1(op1), .op2(op2), .acc(acc), .dptr(dptr),
    .carryIn(carryIn), .cmpA(cmpA), .cmpB(cmpB), .stackHi(stackHi),
    .stackLo(stackLo), .outValid(outValid), .nextPc(nextPc), .taken(taken),
    .carryOut(carryOut)
  );
endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] pc = '0, dptr = '0;
  logic [7:0]  opcode = '0, op1 = '0, op2 = '0, acc = '0;
  logic [7:0]  cmpA = '0, cmpB = '0, loopVal = '0, stackHi = '0, stackLo = '0;
  logic [1:0]  seqLen = 2'd1;
  logic        carryIn = 1'b0, bitVal = 1'b0;
  logic        outValid, taken, carryOut;
  logic [15:0] nextPc;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .pc(pc), .opcode(opcode), .op1(op1),
    .op2(op2), .seqLen(seqLen), .acc(acc), .dptr(dptr), .carryIn(carryIn),
    .bitVal(bitVal), .cmpA(cmpA), .cmpB(cmpB), .loopVal(loopVal),
    .stackHi(stackHi), .stackLo(stackLo), .outValid(outValid), .nextPc(nextPc),
    .taken(taken), .carryOut(carryOut)
  );

  logic [15:0] ePc;
  logic        eTk, eCy;
  string       eReq;

  function automatic logic [15:0] sx(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  // Expected values from the requirements
  task automatic expect_now();
    logic [15:0] nxt;
    logic        c;
    eCy = carryIn;
    eTk = 1'b0;
    if (opcode[3:0] == 4'h1) begin
      nxt = pc + 16'd2;
      ePc = {nxt[15:11], opcode[7:5], op1}; eTk = 1; eReq = "R3";
    end else if (opcode == 8'h02 || opcode == 8'h12) begin
      ePc = {op1, op2}; eTk = 1; eReq = "R4";
    end else if (opcode == 8'h22 || opcode == 8'h32) begin
      ePc = {stackHi, stackLo}; eTk = 1; eReq = "R5";
    end else if (opcode == 8'h73) begin
      ePc = dptr + {8'h00, acc}; eTk = 1; eReq = "R10";
    end else if (opcode == 8'h80) begin
      ePc = pc + 16'd2 + sx(op1); eTk = 1; eReq = "R6";
    end else if (opcode == 8'h40 || opcode == 8'h50) begin
      c = (opcode == 8'h40) ? carryIn : !carryIn;
      ePc = c ? pc + 16'd2 + sx(op1) : pc + 16'd2; eTk = c; eReq = "R7";
    end else if (opcode == 8'h10 || opcode == 8'h20 || opcode == 8'h30) begin
      c = (opcode == 8'h30) ? !bitVal : bitVal;
      ePc = c ? pc + 16'd3 + sx(op2) : pc + 16'd3; eTk = c; eReq = "R8";
    end else if (opcode == 8'h60 || opcode == 8'h70) begin
      c = (opcode == 8'h60) ? (acc == 0) : (acc != 0);
      ePc = c ? pc + 16'd2 + sx(op1) : pc + 16'd2; eTk = c; eReq = "R9";
    end else if (opcode >= 8'hB4 && opcode <= 8'hBF) begin
      c = (cmpA != cmpB);
      ePc = c ? pc + 16'd3 + sx(op2) : pc + 16'd3; eTk = c; eReq = "R11";
      eCy = (cmpA < cmpB);
    end else if (opcode == 8'hD5) begin
      c = (loopVal != 8'd1);
      ePc = c ? pc + 16'd3 + sx(op2) : pc + 16'd3; eTk = c; eReq = "R12";
    end else if (opcode >= 8'hD8 && opcode <= 8'hDF) begin
      c = (loopVal != 8'd1);
      ePc = c ? pc + 16'd2 + sx(op1) : pc + 16'd2; eTk = c; eReq = "R12";
    end else begin
      ePc = pc + {14'd0, seqLen}; eReq = "R2";
    end
  endtask

  task automatic check(input string req, input logic [15:0] aPc, input logic aTk,
                       input logic aCy, input logic aV, input logic [15:0] xPc,
                       input logic xTk, input logic xCy, input logic xV);
    checks++;
    if (aPc !== xPc || aTk !== xTk || aCy !== xCy || aV !== xV) begin
      fails++;
      $display("FAIL %s op=%h pc=%h: got pc=%h tk=%b cy=%b v=%b expected pc=%h tk=%b cy=%b v=%b",
               req, opcode, pc, aPc, aTk, aCy, aV, xPc, xTk, xCy, xV);
    end
  endtask

  // drive one instruction, sample one cycle later away from the edge
  task automatic apply(input string tag);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    expect_now();
    check(tag == "" ? eReq : tag, nextPc, taken, carryOut, outValid, ePc, eTk, eCy, 1'b1);
  endtask

  task automatic setup(input int p, input logic [7:0] opc);
    logic [7:0] b;
    opcode = opc;
    case (p)
      0: begin pc = 16'h0000; b = 8'h7F; end
      1: begin pc = 16'h1234; b = 8'h80; end
      2: begin pc = 16'h7FFE; b = 8'h00; end
      3: begin pc = 16'hFFFE; b = 8'hFF; end
      4: begin pc = 16'h07FD; b = 8'h05; end
      default: begin pc = 16'hF7FF; b = 8'hFE; end
    endcase
    op1 = b;
    op2 = b ^ 8'hC3;
    carryIn = p[0];
    bitVal = p[1];
    acc = (p % 3 == 0) ? 8'h00 : 8'(8'h5A + p);
    dptr = 16'(16'hFF00 + p * 16'h31);
    cmpA = 8'(8'h40 + p);
    cmpB = (p == 2) ? cmpA : ((p < 2) ? 8'h80 : 8'h10);
    loopVal = (p == 1 || p == 4) ? 8'd1 : 8'(p * 8'h7F);
    seqLen = 2'((p % 3) + 1);
    stackHi = 8'(8'hA0 + p);
    stackLo = 8'(8'h0F * p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", nextPc, taken, carryOut, outValid, 16'h0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", nextPc, taken, carryOut, outValid, 16'h0000, 1'b0, 1'b0, 1'b0);

    // R13 directed: wrap and negative offsets
    setup(0, 8'h80); pc = 16'hFFFE; op1 = 8'h05; apply("R13");
    check("R13", nextPc, taken, carryOut, outValid, 16'h0005, 1'b1, carryIn, 1'b1);
    setup(0, 8'h80); pc = 16'h1000; op1 = 8'hFE; apply("R13");
    check("R13", nextPc, taken, carryOut, outValid, 16'h1000, 1'b1, carryIn, 1'b1);
    setup(0, 8'h73); dptr = 16'hFFF0; acc = 8'h20; apply("R10");
    check("R10", nextPc, taken, carryOut, outValid, 16'h0010, 1'b1, carryIn, 1'b1);
    setup(0, 8'hB5); cmpA = 8'h03; cmpB = 8'h90; pc = 16'h0010; op2 = 8'h80; apply("R11");
    check("R11", nextPc, taken, carryOut, outValid, 16'hFF93, 1'b1, 1'b1, 1'b1);
    setup(0, 8'h41); pc = 16'h07FE; op1 = 8'h34; apply("R3");
    check("R3", nextPc, taken, carryOut, outValid, 16'h0A34, 1'b1, carryIn, 1'b1);

    // R2: hold while valid is low
    begin
      logic [15:0] hPc;
      logic        hTk, hCy;
      hPc = nextPc; hTk = taken; hCy = carryOut;
      setup(3, 8'h02);
      carryIn = ~hCy;
      @(negedge clk);
      check("R2", nextPc, taken, carryOut, outValid, hPc, hTk, hCy, 1'b0);
    end

    // near-exhaustive sweep: all opcodes x six contexts
    for (int o = 0; o < 256; o++) begin
      for (int p = 0; p < 6; p++) begin
        setup(p, 8'(o));
        apply("");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule